// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the reset for a processor. It watches two conditions. The first is a digital supply-good flag from an external voltage comparator. The second is an active-low pushbutton. The pushbutton level is formed from a board button and a second active-low request line. That request line lets another supervisory output, such as an early power-fail warning, be looped back as a button press.

Both inputs pass through a two-flop synchroniser. The button level is then debounced, so a new level is accepted only after it has held steady for a set number of clock cycles. While the supply is bad or the debounced button is held, reset is asserted. Once every cause has gone away, a single shared counter keeps reset asserted for a further minimum stretch.

Both time constants are parameters counted in clock cycles. With a 50 MHz clock, the defaults give a debounce of about 10 ms and a stretch of about 130 ms. Reset is provided in two polarities, and each polarity has its own output register. A synchronous system reset brings the block up with reset asserted and the stretch counter loaded.

Top module: `sup_reset_gen`

## Requirements
- R1: If supply_ok_i is sampled low at clock edge n, rst_n_o is 0 after edge n+2, because there are two synchroniser flops and one output register. It stays 0 for as long as supply_ok_i stays low.
- R2: Let m be the first edge that samples supply_ok_i high again, with no other cause present. rst_n_o then stays 0 through edge m+STRETCH_CYCLES+1 and returns to 1 after edge m+STRETCH_CYCLES+2.
- R3: While sys_rst is 1, rst_n_o is 0 and rst_o is 1. Let edge 1 be the first edge after sys_rst is released with the supply good. rst_n_o then rises after edge STRETCH_CYCLES+3.
- R4: The button level is btn_n_i AND chain_req_n_i, and it is active low. A low pulse lasting fewer than DEBOUNCE_CYCLES clock cycles is ignored: rst_n_o stays 1 throughout.
- R5: Let a button low level of at least DEBOUNCE_CYCLES cycles be first sampled at edge n. rst_n_o is then 0 after edge n+DEBOUNCE_CYCLES+2.
- R6: The stretch starts at button release, not at the press. Let m be the first edge that samples the button high after an accepted press. rst_n_o returns to 1 after edge m+DEBOUNCE_CYCLES+STRETCH_CYCLES+2.
- R7: The supply cause and the button cause share one stretch counter. Any cause present during a stretch reloads it, so reset is released STRETCH_CYCLES+1 cycles after the last cause to clear has cleared internally.
- R8: rst_o is the exact complement of rst_n_o on every cycle, including during sys_rst.
- R9: A low level on chain_req_n_i has exactly the same timing and filtering as the same level on btn_n_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| supply_ok_i | input | 1 | Supply-good flag from the comparator, asynchronous, 1 = in tolerance |
| btn_n_i | input | 1 | Pushbutton, asynchronous, active low |
| chain_req_n_i | input | 1 | Looped-back button request, asynchronous, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The bench uses a small configuration and steps through three families of patterns. The first is supply dips of one to six cycles. The second is button pulses on either input, with lengths that run from well under the debounce limit to past it. The third is overlapping supply and button causes. For every pattern, the expected reset level at every edge is computed from the pulse bounds and the two time constants. This separates pulses the debounce filter rejects from pulses it accepts. It shows whether the stretch is counted from release or from the press, and whether a cause that arrives late reloads the shared counter. A separate power-up sequence confirms that reset is held during sys_rst and released after the full stretch.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

    // Synchronised monitor inputs, carried together through the synchroniser.
    typedef struct packed {
        logic supply_good;
        logic btn_n;
    } mon_in_t;

    localparam int unsigned MON_W = $bits(mon_in_t);

    // Idle value of the synchroniser: supply treated as bad, button released.
    localparam mon_in_t MON_RESET = '{supply_good: 1'b0, btn_n: 1'b1};

    // Counter width needed to hold the value 'limit'.
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/srg_sync2.sv
module srg_sync2 #(
    parameter int unsigned       W        = 2,
    parameter logic [W-1:0]      IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= IDLE_VAL;
            q_o    <= IDLE_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/srg_debounce.sv
module srg_debounce
    import sup_reset_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic level_o
);
    localparam int unsigned CW = cnt_bits(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] run_q;

    // The output follows the input only after it has differed for HOLD_CYCLES edges in a row.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_o <= 1'b1;
        end else if (level_i == level_o) begin
            run_q   <= '0;
        end else if (run_q == LAST) begin
            run_q   <= '0;
            level_o <= level_i;
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/srg_stretch.sv
module srg_stretch
    import sup_reset_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic cause_i,
    output logic hold_n_o,
    output logic hold_o
);
    localparam int unsigned CW = cnt_bits(STRETCH_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYCLES);

    logic [CW-1:0] left_q;
    logic          active;

    assign active = cause_i || (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q   <= RELOAD;
            hold_n_o <= 1'b0;
            hold_o   <= 1'b1;
        end else begin
            if (cause_i) begin
                left_q <= RELOAD;
            end else if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
            hold_n_o <= !active;
            hold_o   <= active;
        end
    end
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_reset_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 500_000,
    parameter int unsigned STRETCH_CYCLES  = 6_500_000
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic supply_ok_i,
    input  logic btn_n_i,
    input  logic chain_req_n_i,
    output logic rst_n_o,
    output logic rst_o
);
    mon_in_t raw_in;
    mon_in_t sync_in;
    logic    supply_good_s;
    logic    btn_sync_s;
    logic    btn_level_f;
    logic    cause;

    assign raw_in.supply_good = supply_ok_i;
    assign raw_in.btn_n       = btn_n_i & chain_req_n_i;

    srg_sync2 #(
        .W        (MON_W),
        .IDLE_VAL (MON_RESET)
    ) u_sync (
        .clk (clk),
        .rst (sys_rst),
        .d_i (raw_in),
        .q_o (sync_in)
    );

    assign supply_good_s = sync_in.supply_good;
    assign btn_sync_s    = sync_in.btn_n;

    srg_debounce #(
        .HOLD_CYCLES (DEBOUNCE_CYCLES)
    ) u_deb (
        .clk     (clk),
        .rst     (sys_rst),
        .level_i (btn_sync_s),
        .level_o (btn_level_f)
    );

    assign cause = !supply_good_s || !btn_level_f;

    srg_stretch #(
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_stretch (
        .clk      (clk),
        .rst      (sys_rst),
        .cause_i  (cause),
        .hold_n_o (rst_n_o),
        .hold_o   (rst_o)
    );
endmodule

// File: rtl/sup_reset_checks.sv
module sup_reset_checks
    import sup_reset_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 10
) (
    input logic clk,
    input logic sys_rst,
    input logic supply_good_s,
    input logic btn_sync_s,
    input logic btn_level_f,
    input logic rst_n_o,
    input logic rst_o
);
    localparam int unsigned QW = cnt_bits(STRETCH_CYCLES + 1);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH_CYCLES + 1);

    logic [QW-1:0] quiet_q;

    // Counts cycles without any cause, saturating just past the stretch.
    always_ff @(posedge clk) begin
        if (sys_rst || !supply_good_s || !btn_level_f) begin
            quiet_q <= '0;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assert_polarity_pair_R8: assert property (@(posedge clk) disable iff (sys_rst)
        rst_o == !rst_n_o);

    assert_supply_bad_holds_R1: assert property (@(posedge clk) disable iff (sys_rst)
        !supply_good_s |=> !rst_n_o);

    assert_button_holds_R5: assert property (@(posedge clk) disable iff (sys_rst)
        !btn_level_f |=> !rst_n_o);

    assert_filter_follows_sync_R4: assert property (@(posedge clk) disable iff (sys_rst)
        !$stable(btn_level_f) |-> (btn_level_f == $past(btn_sync_s)));

    assert_min_stretch_R7: assert property (@(posedge clk) disable iff (sys_rst)
        rst_n_o |-> (quiet_q > QW'(STRETCH_CYCLES)));
endmodule

bind sup_reset_gen sup_reset_checks #(
    .STRETCH_CYCLES (STRETCH_CYCLES)
) u_checks (
    .clk           (clk),
    .sys_rst       (sys_rst),
    .supply_good_s (supply_good_s),
    .btn_sync_s    (btn_sync_s),
    .btn_level_f   (btn_level_f),
    .rst_n_o       (rst_n_o),
    .rst_o         (rst_o)
);

// File: tb/sup_reset_gen_test.sv
module sup_reset_gen_test;
    localparam int DEB = 4;
    localparam int STR = 10;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic supply_ok_i = 1'b1;
    logic btn_n_i = 1'b1;
    logic chain_req_n_i = 1'b1;
    logic rst_n_o;
    logic rst_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sup_reset_gen #(
        .DEBOUNCE_CYCLES (DEB),
        .STRETCH_CYCLES  (STR)
    ) uut (
        .clk           (clk),
        .sys_rst       (sys_rst),
        .supply_ok_i   (supply_ok_i),
        .btn_n_i       (btn_n_i),
        .chain_req_n_i (chain_req_n_i),
        .rst_n_o       (rst_n_o),
        .rst_o         (rst_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Whether a cause is present internally after edge j, computed from the pulse bounds.
    function automatic bit cause_at(int j, int s_lo, int s_hi, int b_lo, int b_hi);
        bit sup;
        bit btn;
        sup = (j >= s_lo + 1) && (j <= s_hi);
        btn = ((b_hi - b_lo) >= DEB) && (j >= b_lo + 1 + DEB) && (j <= b_hi + DEB);
        return sup || btn;
    endfunction

    function automatic bit exp_low(int k, int s_lo, int s_hi, int b_lo, int b_hi);
        for (int j = k - 1 - STR; j <= k - 1; j++) begin
            if (j >= 1 && cause_at(j, s_lo, s_hi, b_lo, b_hi)) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Supply is low for edges [s_lo, s_hi) and the button is low for edges [b_lo, b_hi).
    task automatic run_pattern(input string req, input int s_lo, input int s_hi,
                               input int b_lo, input int b_hi, input bit via_chain);
        int len;
        int first_k;
        int f_act;
        int f_exp;
        int comp_bad;
        bit want;
        bit b_raw;
        len = ((s_hi > b_hi) ? s_hi : b_hi) + DEB + STR + 8;
        first_k = -1;
        f_act = 0;
        f_exp = 0;
        comp_bad = 0;
        for (int k = 1; k <= len; k++) begin
            supply_ok_i = !((k >= s_lo) && (k < s_hi));
            b_raw = !((k >= b_lo) && (k < b_hi));
            btn_n_i = via_chain ? 1'b1 : b_raw;
            chain_req_n_i = via_chain ? b_raw : 1'b1;
            @(posedge clk);
            @(negedge clk);
            want = exp_low(k, s_lo, s_hi, b_lo, b_hi);
            if (first_k < 0 && (rst_n_o !== !want)) begin
                first_k = k;
                f_act = int'(rst_n_o);
                f_exp = int'(!want);
            end
            if (rst_o !== !rst_n_o) comp_bad++;
        end
        if (first_k >= 0)
            check(req, $sformatf("rst_n_o at edge %0d (s=[%0d,%0d) b=[%0d,%0d) chain=%0d)",
                  first_k, s_lo, s_hi, b_lo, b_hi, via_chain), f_act, f_exp);
        else
            check(req, "rst_n_o trace", 0, 0);
        check("R8", "cycles where rst_o is not the complement", comp_bad, 0);
    endtask

    initial begin
        int mism;
        int mk;
        int ma;
        int me;
        // R3: held during reset
        repeat (4) @(negedge clk);
        check("R3", "rst_n_o during sys_rst", int'(rst_n_o), 0);
        check("R3", "rst_o during sys_rst", int'(rst_o), 1);
        sys_rst = 1'b0;
        mism = 0; mk = 0; ma = 0; me = 0;
        for (int k = 1; k <= STR + 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_n_o !== (k >= STR + 3) && mism == 0) begin
                mism = 1; mk = k; ma = int'(rst_n_o); me = int'(k >= STR + 3);
            end
        end
        check("R3", $sformatf("power-up release, first bad edge %0d", mk), ma, me);

        // R1, R2: supply dips of several lengths
        for (int h = 1; h <= 6; h++) run_pattern("R1_R2", 2, 2 + h, 0, 0, 1'b0);
        run_pattern("R1", 3, 25, 0, 0, 1'b0);

        // R4, R5, R6: button pulses from under to over the debounce limit
        for (int l = 1; l <= DEB + 3; l++) run_pattern("R4_R5_R6", 0, 0, 2, 2 + l, 1'b0);
        run_pattern("R6", 0, 0, 2, 22, 1'b0);

        // R9: same timing via the looped-back request
        run_pattern("R9", 0, 0, 2, 2 + DEB - 1, 1'b1);
        run_pattern("R9", 0, 0, 2, 2 + DEB, 1'b1);
        run_pattern("R9", 0, 0, 2, 2 + DEB + 4, 1'b1);

        // R7: a late cause reloads the shared stretch counter
        run_pattern("R7", 2 + DEB + 2 + DEB + 5, 2 + DEB + 2 + DEB + 7, 2, 2 + DEB + 2, 1'b0);
        run_pattern("R7", 2, 30, 5, 5 + DEB + 1, 1'b0);
        run_pattern("R7", 2, 5, 4, 4 + DEB + 6, 1'b0);
        run_pattern("R7", 2, 8, 10 + STR, 12 + STR, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule